// File: doc/BRIEF.md
# Single-Outstanding DMA Request Controller

This block is the front end of a DMA engine. A sequencer offers load and store requests on a valid/ready channel. Each request carries a kind, a physical address, a line address, a data block and a length. The block turns each accepted request into a read or write request for the memory directory. It then waits for the matching response before it takes any further work. Only one transaction is ever in flight. Busy-with-read and busy-with-write are kept as separate states, and each of them accepts only its own kind of response.

Every outbound request is held back for a fixed, parameterised number of cycles after it is accepted. It is then offered on a valid/ready channel and held stable until the directory takes it. Responses are always consumed. A data response that completes a read is returned to the sequencer as a one-cycle data pulse. An acknowledge that completes a write becomes a one-cycle write-acknowledge pulse. Request kinds and response kinds that the block does not recognise, and responses that do not fit the current state, set sticky error flags.

Top module: `dma_single_ctrl`

## Requirements
- R1: After reset, `seq_ready` is 1, `dir_req_valid` is 0, both completion pulses are 0 and both error flags are 0.
- R2: A load (`seq_kind` = 2'b01) accepted in the idle state produces an outbound request with `dir_req_kind` = 0 (read). Its address, data and length fields are copied from the request. The block becomes busy-read.
- R3: A store (`seq_kind` = 2'b10) accepted in the idle state produces an outbound request with `dir_req_kind` = 1 (write), with the fields copied in the same way. The block becomes busy-write.
- R4: `dir_req_valid` first rises exactly SEND_DELAY clock edges after the edge that accepted the request.
- R5: While `dir_req_valid` is 1 and `dir_req_ready` is 0, the valid and every outbound field stay unchanged. `dir_req_valid` drops after the accepting edge.
- R6: In either busy state, `seq_ready` is 0.
- R7: In busy-read, once the request has been delivered, a response with `rsp_kind` = 2'b01 (data) and the outstanding line address gives `seq_rdata_valid` = 1 with `seq_rdata` = `rsp_data` in the next cycle, and the block returns to idle.
- R8: In busy-write, once the request has been delivered, a response with `rsp_kind` = 2'b10 (acknowledge) and the outstanding line address gives `seq_wack` = 1 in the next cycle, and the block returns to idle.
- R9: A request whose `seq_kind` is neither 2'b01 nor 2'b10 is consumed, sets `err_req` and sends nothing. The block stays idle.
- R10: Any other response sets `err_proto`, gives no pulse and leaves the state unchanged. This covers an unknown kind, the wrong kind for the state, any response while idle, a response before delivery, and a response with the wrong line address.
- R11: `dir_req_id` always carries the REQ_ID parameter.
- R12: Both error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_valid | input | 1 | Sequencer request valid |
| seq_ready | output | 1 | Block can take a request (idle) |
| seq_kind | input | 2 | 01 load, 10 store, others invalid |
| seq_paddr | input | PADDR_W | Physical address |
| seq_laddr | input | LADDR_W | Line address |
| seq_data | input | DATA_W | Data block |
| seq_len | input | LEN_W | Transfer length |
| dir_req_valid | output | 1 | Outbound request valid |
| dir_req_ready | input | 1 | Directory accepts the request |
| dir_req_kind | output | 1 | 0 read, 1 write |
| dir_req_paddr | output | PADDR_W | Copied physical address |
| dir_req_laddr | output | LADDR_W | Copied line address |
| dir_req_id | output | ID_W | Requestor identifier (REQ_ID) |
| dir_req_data | output | DATA_W | Copied data block |
| dir_req_len | output | LEN_W | Copied length |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Always 1: responses are always consumed |
| rsp_kind | input | 2 | 01 data, 10 acknowledge, others invalid |
| rsp_laddr | input | LADDR_W | Line address of the response |
| rsp_data | input | DATA_W | Returned data block |
| seq_rdata_valid | output | 1 | One-cycle data-return pulse |
| seq_rdata | output | DATA_W | Returned data |
| seq_wack | output | 1 | One-cycle write-acknowledge pulse |
| err_req | output | 1 | Sticky invalid-request flag |
| err_proto | output | 1 | Sticky response protocol error flag |

## Verification
The bench builds the block with the default widths, SEND_DELAY = 6 and REQ_ID = 5. With a delay of six cycles there is a window in which a response can arrive before the request has been delivered, so the early-response error is reachable. The non-zero REQ_ID makes the identifier field visibly different from a reset value. Random directory back-pressure of up to five cycles exercises the hold behaviour, and directed cases cover every kind of mismatched response and an invalid request kind.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BUSY_RD = 2'd1,
    ST_BUSY_WR = 2'd2
  } dsc_state_e;

  localparam logic [1:0] SEQ_LOAD  = 2'b01;
  localparam logic [1:0] SEQ_STORE = 2'b10;
  localparam logic [1:0] RSP_DATA  = 2'b01;
  localparam logic [1:0] RSP_ACK   = 2'b10;
  localparam logic       DIR_READ  = 1'b0;
  localparam logic       DIR_WRITE = 1'b1;

endpackage

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_load,
  input  logic       acc_store,
  input  logic       bad_req,
  input  logic       done_rd,
  input  logic       done_wr,
  output dsc_state_e state,
  output logic       err_req
);

  dsc_state_e state_d;
  logic       err_req_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (acc_load)       state_d = ST_BUSY_RD;
        else if (acc_store) state_d = ST_BUSY_WR;
      end
      ST_BUSY_RD: if (done_rd) state_d = ST_IDLE;
      ST_BUSY_WR: if (done_wr) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_req_d = err_req | bad_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err_req <= 1'b0;
    end else begin
      state   <= state_d;
      err_req <= err_req_d;
    end
  end

endmodule

// File: rtl/dsc_send_slot.sv
module dsc_send_slot #(
  parameter int PADDR_W    = 40,
  parameter int LADDR_W    = 34,
  parameter int DATA_W     = 64,
  parameter int LEN_W      = 8,
  parameter int SEND_DELAY = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               in_kind,
  input  logic [PADDR_W-1:0] in_paddr,
  input  logic [LADDR_W-1:0] in_laddr,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [LEN_W-1:0]   in_len,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_kind,
  output logic [PADDR_W-1:0] out_paddr,
  output logic [LADDR_W-1:0] out_laddr,
  output logic [DATA_W-1:0]  out_data,
  output logic [LEN_W-1:0]   out_len,
  output logic               pend
);

  localparam int CNT_W = (SEND_DELAY < 1) ? 1 : $clog2(SEND_DELAY + 1);
  localparam logic [CNT_W-1:0] DLY = CNT_W'(SEND_DELAY);

  logic [CNT_W-1:0] cnt, cnt_d;
  logic             pend_d;
  logic             cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign out_valid = pend & cnt_zero;

  // Timer and pending flag: the delay is loaded when the request is
  // accepted and counts to zero; the slot then offers the message.
  always_comb begin
    cnt_d  = cnt;
    pend_d = pend;
    if (load) begin
      pend_d = 1'b1;
      cnt_d  = DLY;
    end else if (pend && !cnt_zero) begin
      cnt_d = cnt - 1'b1;
    end else if (out_valid && out_ready) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      pend <= pend_d;
    end
  end

  // Message payload: a data path without reset, written only on accept.
  always_ff @(posedge clk) begin
    if (load) begin
      out_kind  <= in_kind;
      out_paddr <= in_paddr;
      out_laddr <= in_laddr;
      out_data  <= in_data;
      out_len   <= in_len;
    end
  end

endmodule

// File: rtl/dsc_rsp_unit.sv
module dsc_rsp_unit
  import dsc_pkg::*;
#(
  parameter int LADDR_W = 34,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dsc_state_e         state,
  input  logic               pend,
  input  logic [LADDR_W-1:0] out_laddr,
  input  logic               rsp_valid,
  input  logic [1:0]         rsp_kind,
  input  logic [LADDR_W-1:0] rsp_laddr,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               done_rd,
  output logic               done_wr,
  output logic               rdata_valid,
  output logic [DATA_W-1:0]  rdata,
  output logic               wack,
  output logic               err_proto
);

  logic delivered;
  logic addr_hit;
  logic proto_bad;
  logic err_proto_d;

  // A response can match only once the request has left the slot.
  assign delivered = (state != ST_IDLE) && !pend;
  assign addr_hit  = (rsp_laddr == out_laddr);

  always_comb begin
    done_rd = rsp_valid && delivered && addr_hit &&
              (state == ST_BUSY_RD) && (rsp_kind == RSP_DATA);
    done_wr = rsp_valid && delivered && addr_hit &&
              (state == ST_BUSY_WR) && (rsp_kind == RSP_ACK);
    proto_bad   = rsp_valid && !done_rd && !done_wr;
    err_proto_d = err_proto | proto_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_valid <= 1'b0;
      wack        <= 1'b0;
      err_proto   <= 1'b0;
    end else begin
      rdata_valid <= done_rd;
      wack        <= done_wr;
      err_proto   <= err_proto_d;
    end
  end

  always_ff @(posedge clk) begin
    if (done_rd) rdata <= rsp_data;
  end

endmodule

// File: rtl/dma_single_ctrl.sv
module dma_single_ctrl
  import dsc_pkg::*;
#(
  parameter int                PADDR_W    = 40,
  parameter int                LADDR_W    = 34,
  parameter int                DATA_W     = 64,
  parameter int                LEN_W      = 8,
  parameter int                ID_W       = 4,
  parameter logic [ID_W-1:0]   REQ_ID     = 3,
  parameter int                SEND_DELAY = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seq_valid,
  output logic               seq_ready,
  input  logic [1:0]         seq_kind,
  input  logic [PADDR_W-1:0] seq_paddr,
  input  logic [LADDR_W-1:0] seq_laddr,
  input  logic [DATA_W-1:0]  seq_data,
  input  logic [LEN_W-1:0]   seq_len,
  output logic               dir_req_valid,
  input  logic               dir_req_ready,
  output logic               dir_req_kind,
  output logic [PADDR_W-1:0] dir_req_paddr,
  output logic [LADDR_W-1:0] dir_req_laddr,
  output logic [ID_W-1:0]    dir_req_id,
  output logic [DATA_W-1:0]  dir_req_data,
  output logic [LEN_W-1:0]   dir_req_len,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [1:0]         rsp_kind,
  input  logic [LADDR_W-1:0] rsp_laddr,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               seq_rdata_valid,
  output logic [DATA_W-1:0]  seq_rdata,
  output logic               seq_wack,
  output logic               err_req,
  output logic               err_proto
);

  dsc_state_e state;
  logic       seq_fire;
  logic       acc_load;
  logic       acc_store;
  logic       bad_req;
  logic       done_rd;
  logic       done_wr;
  logic       pend;

  assign seq_ready  = (state == ST_IDLE);
  assign seq_fire   = seq_valid && seq_ready;
  assign acc_load   = seq_fire && (seq_kind == SEQ_LOAD);
  assign acc_store  = seq_fire && (seq_kind == SEQ_STORE);
  assign bad_req    = seq_fire && !acc_load && !acc_store;
  assign rsp_ready  = 1'b1;
  assign dir_req_id = REQ_ID;

  dsc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_load  (acc_load),
    .acc_store (acc_store),
    .bad_req   (bad_req),
    .done_rd   (done_rd),
    .done_wr   (done_wr),
    .state     (state),
    .err_req   (err_req)
  );

  dsc_send_slot #(
    .PADDR_W    (PADDR_W),
    .LADDR_W    (LADDR_W),
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .SEND_DELAY (SEND_DELAY)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_load || acc_store),
    .in_kind   (acc_store ? DIR_WRITE : DIR_READ),
    .in_paddr  (seq_paddr),
    .in_laddr  (seq_laddr),
    .in_data   (seq_data),
    .in_len    (seq_len),
    .out_ready (dir_req_ready),
    .out_valid (dir_req_valid),
    .out_kind  (dir_req_kind),
    .out_paddr (dir_req_paddr),
    .out_laddr (dir_req_laddr),
    .out_data  (dir_req_data),
    .out_len   (dir_req_len),
    .pend      (pend)
  );

  dsc_rsp_unit #(
    .LADDR_W (LADDR_W),
    .DATA_W  (DATA_W)
  ) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .pend        (pend),
    .out_laddr   (dir_req_laddr),
    .rsp_valid   (rsp_valid),
    .rsp_kind    (rsp_kind),
    .rsp_laddr   (rsp_laddr),
    .rsp_data    (rsp_data),
    .done_rd     (done_rd),
    .done_wr     (done_wr),
    .rdata_valid (seq_rdata_valid),
    .rdata       (seq_rdata),
    .wack        (seq_wack),
    .err_proto   (err_proto)
  );

endmodule

// File: rtl/dma_single_ctrl_chk.sv
module dma_single_ctrl_chk #(
  parameter int              PADDR_W    = 40,
  parameter int              LADDR_W    = 34,
  parameter int              DATA_W     = 64,
  parameter int              LEN_W      = 8,
  parameter int              ID_W       = 4,
  parameter logic [ID_W-1:0] REQ_ID     = 3,
  parameter int              SEND_DELAY = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               seq_valid,
  input logic               seq_ready,
  input logic [1:0]         seq_kind,
  input logic               dir_req_valid,
  input logic               dir_req_ready,
  input logic               dir_req_kind,
  input logic [PADDR_W-1:0] dir_req_paddr,
  input logic [LADDR_W-1:0] dir_req_laddr,
  input logic [ID_W-1:0]    dir_req_id,
  input logic [DATA_W-1:0]  dir_req_data,
  input logic [LEN_W-1:0]   dir_req_len,
  input logic               rsp_valid,
  input logic [1:0]         rsp_kind,
  input logic               seq_rdata_valid,
  input logic               seq_wack,
  input logic               err_req,
  input logic               err_proto
);

  localparam int WC_W = $clog2(SEND_DELAY + 2) + 1;
  localparam logic [WC_W-1:0] WC_MAX = '1;

  logic            acc;
  logic [WC_W-1:0] wcnt;

  assign acc = seq_valid && seq_ready &&
               (seq_kind == 2'b01 || seq_kind == 2'b10);

  // Cycles since the last accepted request, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wcnt <= WC_MAX;
    else if (acc)            wcnt <= '0;
    else if (wcnt != WC_MAX) wcnt <= wcnt + 1'b1;
  end

  a_r2_load_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && seq_ready && seq_kind == 2'b01) |=> !seq_ready);

  a_r3_store_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && seq_ready && seq_kind == 2'b10) |=> !seq_ready);

  a_r4_send_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_req_valid) |-> (wcnt == WC_W'(SEND_DELAY)));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_req_valid && !dir_req_ready) |=>
      (dir_req_valid && $stable(dir_req_kind) && $stable(dir_req_paddr) &&
       $stable(dir_req_laddr) && $stable(dir_req_data) && $stable(dir_req_len)));

  a_r6_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req_valid |-> !seq_ready);

  a_r7_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_rdata_valid, seq_wack}));

  a_r9_bad_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && seq_ready && seq_kind != 2'b01 && seq_kind != 2'b10) |=>
      (err_req && seq_ready && !dir_req_valid));

  a_r10_bad_rsp_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != 2'b01 && rsp_kind != 2'b10) |=>
      (err_proto && !seq_rdata_valid && !seq_wack));

  a_r11_req_id: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req_valid |-> (dir_req_id == REQ_ID));

  a_r12_sticky_req: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |=> err_req);

  a_r12_sticky_proto: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto |=> err_proto);

endmodule

bind dma_single_ctrl dma_single_ctrl_chk #(
  .PADDR_W    (PADDR_W),
  .LADDR_W    (LADDR_W),
  .DATA_W     (DATA_W),
  .LEN_W      (LEN_W),
  .ID_W       (ID_W),
  .REQ_ID     (REQ_ID),
  .SEND_DELAY (SEND_DELAY)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .seq_valid       (seq_valid),
  .seq_ready       (seq_ready),
  .seq_kind        (seq_kind),
  .dir_req_valid   (dir_req_valid),
  .dir_req_ready   (dir_req_ready),
  .dir_req_kind    (dir_req_kind),
  .dir_req_paddr   (dir_req_paddr),
  .dir_req_laddr   (dir_req_laddr),
  .dir_req_id      (dir_req_id),
  .dir_req_data    (dir_req_data),
  .dir_req_len     (dir_req_len),
  .rsp_valid       (rsp_valid),
  .rsp_kind        (rsp_kind),
  .seq_rdata_valid (seq_rdata_valid),
  .seq_wack        (seq_wack),
  .err_req         (err_req),
  .err_proto       (err_proto)
);

// File: tb/tb_dma_single_ctrl.sv
`timescale 1ns/1ps
module tb_dma_single_ctrl;

  localparam int PADDR_W = 40;
  localparam int LADDR_W = 34;
  localparam int DATA_W  = 64;
  localparam int LEN_W   = 8;
  localparam int ID_W    = 4;
  localparam logic [ID_W-1:0] REQ_ID = 4'd5;
  localparam int SEND_DELAY = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic seq_valid, seq_ready;
  logic [1:0] seq_kind;
  logic [PADDR_W-1:0] seq_paddr;
  logic [LADDR_W-1:0] seq_laddr;
  logic [DATA_W-1:0]  seq_data;
  logic [LEN_W-1:0]   seq_len;
  logic dir_req_valid, dir_req_ready, dir_req_kind;
  logic [PADDR_W-1:0] dir_req_paddr;
  logic [LADDR_W-1:0] dir_req_laddr;
  logic [ID_W-1:0]    dir_req_id;
  logic [DATA_W-1:0]  dir_req_data;
  logic [LEN_W-1:0]   dir_req_len;
  logic rsp_valid, rsp_ready;
  logic [1:0] rsp_kind;
  logic [LADDR_W-1:0] rsp_laddr;
  logic [DATA_W-1:0]  rsp_data;
  logic seq_rdata_valid, seq_wack, err_req, err_proto;
  logic [DATA_W-1:0] seq_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dma_single_ctrl #(
    .PADDR_W(PADDR_W), .LADDR_W(LADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .ID_W(ID_W), .REQ_ID(REQ_ID), .SEND_DELAY(SEND_DELAY)
  ) dut (.*);

  function automatic logic exp_dir_kind(input logic [1:0] k);
    return (k == 2'b10) ? 1'b1 : 1'b0;
  endfunction

  function automatic logic [1:0] exp_rsp_kind(input logic [1:0] k);
    return (k == 2'b10) ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [PADDR_W-1:0] e_paddr;
  logic [LADDR_W-1:0] e_laddr;
  logic [DATA_W-1:0]  e_data;
  logic [LEN_W-1:0]   e_len;

  // Offer a request, check the delay and fields, then deliver it after
  // hold_cycles of back-pressure.
  task automatic issue(input logic [1:0] kind, input int hold_cycles,
                       input bit deliver);
    int k;
    e_paddr = {$urandom, $urandom};
    e_laddr = {$urandom, $urandom};
    e_data  = {$urandom, $urandom};
    e_len   = LEN_W'($urandom);
    @(negedge clk);
    chk(seq_ready == 1'b1, "R6 ready before accept", 64'(seq_ready), 1);
    seq_valid = 1'b1; seq_kind = kind; seq_paddr = e_paddr;
    seq_laddr = e_laddr; seq_data = e_data; seq_len = e_len;
    @(negedge clk);
    seq_valid = 1'b0;
    chk(seq_ready == 1'b0, "R6 busy stalls sequencer", 64'(seq_ready), 0);
    if (deliver) begin
      k = 0;
      while (!dir_req_valid && k < 100) begin
        k++;
        @(negedge clk);
      end
      chk(k == SEND_DELAY, "R4 send delay", 64'(k), 64'(SEND_DELAY));
      chk(dir_req_kind == exp_dir_kind(kind), (kind == 2'b01) ? "R2 read kind" : "R3 write kind",
          64'(dir_req_kind), 64'(exp_dir_kind(kind)));
      chk(dir_req_paddr == e_paddr && dir_req_laddr == e_laddr &&
          dir_req_data == e_data && dir_req_len == e_len,
          "R2 R3 fields copied", 64'(dir_req_data), e_data);
      chk(dir_req_id == REQ_ID, "R11 requestor id", 64'(dir_req_id), 64'(REQ_ID));
      for (int h = 0; h < hold_cycles; h++) begin
        @(negedge clk);
        chk(dir_req_valid && dir_req_paddr == e_paddr && dir_req_data == e_data &&
            dir_req_len == e_len && dir_req_laddr == e_laddr,
            "R5 held under back-pressure", 64'(dir_req_valid), 1);
      end
      dir_req_ready = 1'b1;
      @(negedge clk);
      dir_req_ready = 1'b0;
      chk(dir_req_valid == 1'b0, "R5 valid drops after accept", 64'(dir_req_valid), 0);
    end
  endtask

  task automatic respond(input logic [1:0] kind, input logic [LADDR_W-1:0] la,
                         input logic [DATA_W-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = kind; rsp_laddr = la; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic complete(input logic [1:0] kind);
    logic [DATA_W-1:0] rd;
    rd = {$urandom, $urandom};
    respond(exp_rsp_kind(kind), e_laddr, rd);
    if (kind == 2'b01) begin
      chk(seq_rdata_valid == 1'b1 && seq_rdata == rd, "R7 data return",
          seq_rdata, rd);
    end else begin
      chk(seq_wack == 1'b1 && seq_rdata_valid == 1'b0, "R8 write ack",
          64'(seq_wack), 1);
    end
    chk(seq_ready == 1'b1, "R7 R8 back to idle", 64'(seq_ready), 1);
    @(negedge clk);
    chk(seq_rdata_valid == 1'b0 && seq_wack == 1'b0, "R7 R8 single pulse",
        64'({seq_rdata_valid, seq_wack}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; seq_valid = 1'b0; seq_kind = 2'b00; seq_paddr = '0;
    seq_laddr = '0; seq_data = '0; seq_len = '0; dir_req_ready = 1'b0;
    rsp_valid = 1'b0; rsp_kind = 2'b00; rsp_laddr = '0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(seq_ready == 1'b1 && dir_req_valid == 1'b0, "R1 reset state",
        64'({seq_ready, dir_req_valid}), 64'b10);
    chk(!seq_rdata_valid && !seq_wack && !err_req && !err_proto, "R1 reset flags",
        64'({seq_rdata_valid, seq_wack, err_req, err_proto}), 0);

    // Random legal traffic
    for (int i = 0; i < 24; i++) begin
      logic [1:0] kind;
      kind = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      issue(kind, int'($urandom % 6), 1'b1);
      repeat (int'($urandom % 3)) @(negedge clk);
      complete(kind);
    end
    chk(!err_req && !err_proto, "R10 no error on legal traffic",
        64'({err_req, err_proto}), 0);

    // R10: acknowledge while idle
    respond(2'b10, '0, '0);
    chk(err_proto && !seq_wack && seq_ready, "R10 response while idle",
        64'({err_proto, seq_wack, seq_ready}), 64'b101);

    // R10: response before delivery, then wrong kind, wrong line, bad kind
    issue(2'b01, 0, 1'b0);
    respond(2'b01, e_laddr, 64'h1);
    chk(!seq_rdata_valid && !seq_ready, "R10 early response ignored",
        64'({seq_rdata_valid, seq_ready}), 0);
    k_wait_deliver();
    respond(2'b10, e_laddr, '0);
    chk(!seq_wack && !seq_ready, "R10 ack in busy-read ignored",
        64'({seq_wack, seq_ready}), 0);
    respond(2'b01, e_laddr ^ 1, 64'h2);
    chk(!seq_rdata_valid && !seq_ready, "R10 wrong line ignored",
        64'({seq_rdata_valid, seq_ready}), 0);
    respond(2'b11, e_laddr, 64'h3);
    chk(!seq_rdata_valid && !seq_ready, "R10 unknown kind ignored",
        64'({seq_rdata_valid, seq_ready}), 0);
    complete(2'b01);

    issue(2'b10, 1, 1'b1);
    respond(2'b01, e_laddr, '0);
    chk(!seq_rdata_valid && !seq_wack && !seq_ready, "R10 data in busy-write ignored",
        64'({seq_rdata_valid, seq_wack, seq_ready}), 0);
    complete(2'b10);

    // R9: invalid request kinds
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      seq_valid = 1'b1; seq_kind = (b == 0) ? 2'b11 : 2'b00;
      @(negedge clk);
      seq_valid = 1'b0;
      chk(err_req && seq_ready, "R9 bad request consumed", 64'({err_req, seq_ready}), 64'b11);
      for (int w = 0; w < SEND_DELAY + 2; w++) begin
        @(negedge clk);
        if (dir_req_valid) chk(1'b0, "R9 nothing sent", 1, 0);
      end
      chk(!dir_req_valid && seq_ready, "R9 stays idle", 64'(dir_req_valid), 0);
    end

    // R12: flags survive more legal traffic, clear only on reset
    issue(2'b01, 0, 1'b1);
    complete(2'b01);
    chk(err_req && err_proto, "R12 flags sticky", 64'({err_req, err_proto}), 64'b11);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!err_req && !err_proto && seq_ready, "R12 R1 cleared by reset",
        64'({err_req, err_proto, seq_ready}), 64'b001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Wait out the send delay and let the directory take the request.
  task automatic k_wait_deliver();
    int k;
    k = 0;
    while (!dir_req_valid && k < 100) begin
      k++;
      @(negedge clk);
    end
    chk(dir_req_valid == 1'b1, "R4 request eventually offered", 64'(dir_req_valid), 1);
    dir_req_ready = 1'b1;
    @(negedge clk);
    dir_req_ready = 1'b0;
  endtask

endmodule